// File: doc/BRIEF.md
# Raw Ethernet Command Frame Parser

This block sits behind an Ethernet MAC receive port. It takes raw frames one byte per cycle and treats the six bytes that would normally carry the destination address as a command header. The header carries a serial number, a frame type, a channel number with frame-marker flags, and a payload size. The parser decodes this header and then handles the frame according to its type.

A write frame has its payload, which starts after the 14-byte Ethernet header, streamed out on one of four channel outputs. Each payload byte comes with first, last and last-with-error markers. When the frame ends cleanly, an acknowledge strobe is raised towards the transmit side, together with the serial number, channel and size. A read frame produces a read-request strobe with its serial number and channel. Every other frame type is dropped. A frame that the MAC flags as errored, or that ends before its header is complete, raises no strobe. The MAC checks the CRC before the frame reaches this block.

Top module: `eth_cmd_parser`

## Requirements
- R1: After reset, `ch_valid`, `ch_first`, `ch_last`, `ch_lerr`, `rd_req_stb` and `ack_stb` are low, and `tx_serial`, `tx_chan` and `tx_size` are zero.
- R2: The header is laid out as follows. Frame byte 0 is the serial number high byte and byte 1 its low byte. Byte 2 is the type. In byte 3, bits 7:6 are the channel, bit 0 is SOF, bit 1 is EOF and bit 2 is EOFE; bits 5:3 are ignored. Byte 4 is the size high byte and byte 5 its low byte. Bytes 6 to 13 are ignored, and the payload starts at byte 14.
- R3: For a Write frame (type 0x02), each payload byte appears on `ch_data` one cycle after its input beat. `ch_valid` has only the bit of the header channel set. Cycles with `rx_valid` low are skipped.
- R4: The number of payload bytes forwarded is at most the size field, and never more than MAX_PAYLOAD (default 8192). Bytes beyond that limit produce no output.
- R5: `ch_first` is high on the first forwarded byte exactly when SOF is set. `ch_last` is high on the byte at position limit-1 exactly when EOF or EOFE is set. `ch_lerr` goes with that same byte exactly when EOFE is set.
- R6: A Write frame that ends without error pulses `ack_stb` for one cycle, in the cycle after its last beat. `tx_serial`, `tx_chan` and `tx_size` carry the header values in that cycle.
- R7: A Read frame (type 0x03) that ends without error pulses `rd_req_stb` for one cycle, in the cycle after its last beat, with `tx_serial` and `tx_chan` set. It forwards no payload.
- R8: Null (0x00), Poll (0x01) and any other type raise no strobe and forward no payload.
- R9: A frame that has `rx_err` on any beat, or that ends with fewer than 14 bytes, raises no strobe. Payload from the errored beat onward is not forwarded.
- R10: `tx_serial`, `tx_chan` and `tx_size` change only in a cycle where a strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_first | input | 1 | Beat is the first byte of a frame |
| rx_last | input | 1 | Beat is the last byte of a frame |
| rx_err | input | 1 | MAC reports an error on this frame |
| ch_valid | output | 4 | One-hot payload valid per channel |
| ch_data | output | 8 | Payload byte |
| ch_first | output | 1 | First payload byte marker |
| ch_last | output | 1 | Last payload byte marker |
| ch_lerr | output | 1 | Last byte, ended with error |
| rd_req_stb | output | 1 | Read request strobe to transmitter |
| ack_stb | output | 1 | Acknowledge strobe to transmitter |
| tx_serial | output | 16 | Serial number for transmitter |
| tx_chan | output | 2 | Channel for transmitter |
| tx_size | output | 16 | Size field for transmitter |

## Verification
When a write frame carries exactly as many payload bytes as its size field and has no padding, its final payload byte leaves on the channel output in the same cycle that `ack_stb` rises. The bench sends such frames, with and without idle gaps in the middle. It records the cycle of the last forwarded byte and the cycle of the strobe and requires them to be equal. It also checks that the byte and the strobe are both correct in that cycle, with the right last marker on the byte and the right serial number and size on the strobe.

// File: rtl/ecp_pkg.sv
package ecp_pkg;
  localparam int HDR_BYTES = 14;
  localparam int NUM_CH    = 4;
  localparam int CH_W      = 2;
  localparam logic [7:0] FT_NULL  = 8'h00;
  localparam logic [7:0] FT_POLL  = 8'h01;
  localparam logic [7:0] FT_WRITE = 8'h02;
  localparam logic [7:0] FT_READ  = 8'h03;
  localparam int MK_SOF  = 0;
  localparam int MK_EOF  = 1;
  localparam int MK_EOFE = 2;

  typedef struct packed {
    logic [15:0]     serial;
    logic [7:0]      ftype;
    logic [CH_W-1:0] chan;
    logic [2:0]      marks;
    logic [15:0]     size;
  } cmd_hdr_t;
endpackage

// File: rtl/ecp_frame_track.sv
module ecp_frame_track
  import ecp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_first,
  input  logic       rx_last,
  input  logic       rx_err,
  output cmd_hdr_t   hdr,
  output logic       beat,
  output logic       pay_beat,
  output logic       beat_bad,
  output logic       end_ok
);
  localparam int IDX_W = $clog2(HDR_BYTES + 1);
  localparam logic [IDX_W-1:0] IDX_PAY  = IDX_W'(HDR_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HDR_BYTES - 1);

  logic             in_frame_q;
  logic             bad_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] cur_idx;
  logic             unused_hdr_bits;

  assign unused_hdr_bits = &{1'b0, rx_data[5:3]};

  always_comb begin
    beat     = rx_valid && (rx_first || in_frame_q);
    cur_idx  = rx_first ? '0 : idx_q;
    beat_bad = (rx_first ? 1'b0 : bad_q) || rx_err;
    pay_beat = beat && (cur_idx == IDX_PAY);
    end_ok   = beat && rx_last && !beat_bad && (cur_idx >= IDX_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame_q <= 1'b0;
      bad_q      <= 1'b0;
      idx_q      <= '0;
      hdr        <= '0;
    end else if (beat) begin
      in_frame_q <= !rx_last;
      bad_q      <= beat_bad;
      idx_q      <= (cur_idx == IDX_PAY) ? cur_idx : cur_idx + 1'b1;
      case (cur_idx)
        IDX_W'(0): hdr.serial[15:8] <= rx_data;
        IDX_W'(1): hdr.serial[7:0]  <= rx_data;
        IDX_W'(2): hdr.ftype        <= rx_data;
        IDX_W'(3): begin
          hdr.chan  <= rx_data[7:6];
          hdr.marks <= rx_data[2:0];
        end
        IDX_W'(4): hdr.size[15:8]   <= rx_data;
        IDX_W'(5): hdr.size[7:0]    <= rx_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ecp_payload_router.sv
module ecp_payload_router
  import ecp_pkg::*;
#(
  parameter int MAX_PAYLOAD = 8192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              new_frame,
  input  logic              beat_pay,
  input  logic [7:0]        rx_data,
  input  logic [CH_W-1:0]   chan,
  input  logic [2:0]        marks,
  input  logic [15:0]       size,
  output logic [NUM_CH-1:0] ch_valid,
  output logic [7:0]        ch_data,
  output logic              ch_first,
  output logic              ch_last,
  output logic              ch_lerr
);
  localparam int CNT_W = $clog2(MAX_PAYLOAD + 1);

  logic [CNT_W-1:0] pcount_q;
  logic [CNT_W-1:0] limit;
  logic             fwd;
  logic             at_end;

  always_comb begin
    limit  = (32'(size) > MAX_PAYLOAD) ? CNT_W'(MAX_PAYLOAD) : CNT_W'(size);
    fwd    = beat_pay && (pcount_q < limit);
    at_end = (pcount_q == limit - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst)            pcount_q <= '0;
    else if (new_frame) pcount_q <= '0;
    else if (fwd)       pcount_q <= pcount_q + 1'b1;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) ch_valid[c] <= 1'b0;
      else     ch_valid[c] <= fwd && (chan == CH_W'(c));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_data  <= '0;
      ch_first <= 1'b0;
      ch_last  <= 1'b0;
      ch_lerr  <= 1'b0;
    end else begin
      if (fwd) ch_data <= rx_data;
      ch_first <= fwd && marks[MK_SOF] && (pcount_q == '0);
      ch_last  <= fwd && at_end && (marks[MK_EOF] || marks[MK_EOFE]);
      ch_lerr  <= fwd && at_end && marks[MK_EOFE];
    end
  end
endmodule

// File: rtl/ecp_dispatch.sv
module ecp_dispatch
  import ecp_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            end_ok,
  input  logic [15:0]     serial,
  input  logic [7:0]      ftype,
  input  logic [CH_W-1:0] chan,
  input  logic [15:0]     size,
  output logic            rd_req_stb,
  output logic            ack_stb,
  output logic [15:0]     tx_serial,
  output logic [CH_W-1:0] tx_chan,
  output logic [15:0]     tx_size
);
  logic is_rd, is_wr;

  always_comb begin
    is_rd = end_ok && (ftype == FT_READ);
    is_wr = end_ok && (ftype == FT_WRITE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req_stb <= 1'b0;
      ack_stb    <= 1'b0;
      tx_serial  <= '0;
      tx_chan    <= '0;
      tx_size    <= '0;
    end else begin
      rd_req_stb <= is_rd;
      ack_stb    <= is_wr;
      if (is_rd || is_wr) begin
        tx_serial <= serial;
        tx_chan   <= chan;
        tx_size   <= size;
      end
    end
  end
endmodule

// File: rtl/eth_cmd_parser.sv
module eth_cmd_parser
  import ecp_pkg::*;
#(
  parameter int MAX_PAYLOAD = 8192
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_first,
  input  logic        rx_last,
  input  logic        rx_err,
  output logic [3:0]  ch_valid,
  output logic [7:0]  ch_data,
  output logic        ch_first,
  output logic        ch_last,
  output logic        ch_lerr,
  output logic        rd_req_stb,
  output logic        ack_stb,
  output logic [15:0] tx_serial,
  output logic [1:0]  tx_chan,
  output logic [15:0] tx_size
);
  cmd_hdr_t hdr;
  logic     beat, pay_beat, beat_bad, end_ok;
  logic     new_frame, beat_pay;

  assign new_frame = beat && rx_first;
  assign beat_pay  = pay_beat && !beat_bad && (hdr.ftype == FT_WRITE);

  ecp_frame_track u_track (
    .clk(clk), .rst(rst),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_first(rx_first),
    .rx_last(rx_last), .rx_err(rx_err),
    .hdr(hdr), .beat(beat), .pay_beat(pay_beat),
    .beat_bad(beat_bad), .end_ok(end_ok)
  );

  ecp_payload_router #(.MAX_PAYLOAD(MAX_PAYLOAD)) u_route (
    .clk(clk), .rst(rst),
    .new_frame(new_frame), .beat_pay(beat_pay), .rx_data(rx_data),
    .chan(hdr.chan), .marks(hdr.marks), .size(hdr.size),
    .ch_valid(ch_valid), .ch_data(ch_data),
    .ch_first(ch_first), .ch_last(ch_last), .ch_lerr(ch_lerr)
  );

  ecp_dispatch u_disp (
    .clk(clk), .rst(rst), .end_ok(end_ok),
    .serial(hdr.serial), .ftype(hdr.ftype), .chan(hdr.chan), .size(hdr.size),
    .rd_req_stb(rd_req_stb), .ack_stb(ack_stb),
    .tx_serial(tx_serial), .tx_chan(tx_chan), .tx_size(tx_size)
  );
endmodule

// File: rtl/eth_cmd_parser_chk.sv
module eth_cmd_parser_chk (
  input logic        clk,
  input logic        rst,
  input logic        rx_valid,
  input logic        rx_last,
  input logic        rx_err,
  input logic [3:0]  ch_valid,
  input logic        ch_first,
  input logic        ch_last,
  input logic        ch_lerr,
  input logic        rd_req_stb,
  input logic        ack_stb,
  input logic [15:0] tx_serial,
  input logic [1:0]  tx_chan,
  input logic [15:0] tx_size
);
  AST_CH_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_valid)); // R3
  AST_MARK_QUAL: assert property (@(posedge clk) disable iff (rst)
    (ch_first || ch_last || ch_lerr) |-> (|ch_valid)); // R5
  AST_LERR_LAST: assert property (@(posedge clk) disable iff (rst)
    ch_lerr |-> ch_last); // R5
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rd_req_stb && ack_stb)); // R6
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    ack_stb |=> !ack_stb); // R6
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_req_stb |=> !rd_req_stb); // R7
  AST_ERR_NO_STB: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_last && rx_err) |=> (!rd_req_stb && !ack_stb)); // R9
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rd_req_stb && !ack_stb) |-> ($stable(tx_serial) && $stable(tx_chan) && $stable(tx_size))); // R10
endmodule

bind eth_cmd_parser eth_cmd_parser_chk u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_last(rx_last), .rx_err(rx_err),
  .ch_valid(ch_valid), .ch_first(ch_first), .ch_last(ch_last), .ch_lerr(ch_lerr),
  .rd_req_stb(rd_req_stb), .ack_stb(ack_stb),
  .tx_serial(tx_serial), .tx_chan(tx_chan), .tx_size(tx_size)
);

// File: tb/tb_eth_cmd_parser.sv
module tb_eth_cmd_parser;
  localparam int CLK_PERIOD = 10;
  localparam int TB_MAX     = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0, rx_first = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic [3:0]  ch_valid;
  logic [7:0]  ch_data;
  logic        ch_first, ch_last, ch_lerr, rd_req_stb, ack_stb;
  logic [15:0] tx_serial, tx_size;
  logic [1:0]  tx_chan;

  eth_cmd_parser #(.MAX_PAYLOAD(TB_MAX)) dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_first(rx_first), .rx_last(rx_last), .rx_err(rx_err),
    .ch_valid(ch_valid), .ch_data(ch_data), .ch_first(ch_first),
    .ch_last(ch_last), .ch_lerr(ch_lerr), .rd_req_stb(rd_req_stb),
    .ack_stb(ack_stb), .tx_serial(tx_serial), .tx_chan(tx_chan), .tx_size(tx_size)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  int byte_cyc = -1, stb_cyc = -1;
  logic [12:0] exp_b[$], obs_b[$];
  logic [35:0] exp_s[$], obs_s[$];

  function automatic logic [1:0] oh2idx(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return 2'(i);
    return 2'd0;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (|ch_valid) begin
      obs_b.push_back({oh2idx(ch_valid), ch_first, ch_last, ch_lerr, ch_data});
      byte_cyc = cyc;
    end
    if (rd_req_stb || ack_stb) begin
      obs_s.push_back({ack_stb, rd_req_stb, tx_serial, tx_chan, tx_size});
      stb_cyc = cyc;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] d, input bit f, input bit l, input bit e);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_first = f; rx_last = l; rx_err = e;
  endtask

  task automatic idle();
    @(negedge clk);
    rx_valid = 1'b0; rx_first = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
  endtask

  // Builds, drives and judges one frame. err_at < 0 means no error beat.
  task automatic run_frame(input logic [15:0] ser, input logic [7:0] ft,
                           input logic [7:0] b3, input logic [15:0] sz,
                           input int len, input int err_at, input bit gaps);
    logic [7:0] fb[$];
    int lim;
    bit ok;
    fb.delete(); exp_b.delete(); exp_s.delete(); obs_b.delete(); obs_s.delete();
    for (int i = 0; i < len; i++) begin
      case (i)
        0: fb.push_back(ser[15:8]);
        1: fb.push_back(ser[7:0]);
        2: fb.push_back(ft);
        3: fb.push_back(b3);
        4: fb.push_back(sz[15:8]);
        5: fb.push_back(sz[7:0]);
        default: fb.push_back(8'($urandom));
      endcase
    end
    lim = (int'(sz) > TB_MAX) ? TB_MAX : int'(sz);
    ok  = (err_at < 0) && (len >= 14);
    if (ft == 8'h02) begin
      for (int i = 14; i < len; i++) begin
        int k = i - 14;
        if (err_at >= 0 && i >= err_at) break;
        if (k < lim)
          exp_b.push_back({b3[7:6], b3[0] && k == 0, (b3[1] || b3[2]) && k == lim - 1,
                           b3[2] && k == lim - 1, fb[i]});
      end
    end
    if (ok && ft == 8'h02) exp_s.push_back({1'b1, 1'b0, ser, b3[7:6], sz});
    if (ok && ft == 8'h03) exp_s.push_back({1'b0, 1'b1, ser, b3[7:6], sz});
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 4 == 0)) idle();
      drive(fb[i], i == 0, i == len - 1, i == err_at);
    end
    idle();
    repeat (3) @(negedge clk);
    check(obs_b.size() == exp_b.size(), "R4", "payload byte count", obs_b.size(), exp_b.size());
    for (int i = 0; i < exp_b.size() && i < obs_b.size(); i++) begin
      check(obs_b[i][12:11] == exp_b[i][12:11] && obs_b[i][7:0] == exp_b[i][7:0],
            "R3", "payload channel/data", obs_b[i], exp_b[i]);
      check(obs_b[i][10:8] == exp_b[i][10:8], "R5", "first/last/lerr marks",
            obs_b[i][10:8], exp_b[i][10:8]);
    end
    check(obs_s.size() == exp_s.size(), (ft == 8'h03) ? "R7" : ((ft == 8'h02) ? "R6" : "R8"),
          "strobe count", obs_s.size(), exp_s.size());
    if (obs_s.size() == 1 && exp_s.size() == 1) begin
      check(obs_s[0][35:34] == exp_s[0][35:34], "R7", "strobe kind", obs_s[0][35:34], exp_s[0][35:34]);
      check(obs_s[0][33:16] == exp_s[0][33:16], "R2", "serial/channel", obs_s[0][33:16], exp_s[0][33:16]);
      if (ft == 8'h02)
        check(obs_s[0][15:0] == exp_s[0][15:0], "R6", "ack size", obs_s[0][15:0], exp_s[0][15:0]);
    end
  endtask

  initial begin
    logic [15:0] held;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(ch_valid == 4'h0 && !ch_first && !ch_last && !ch_lerr, "R1", "channel outputs", ch_valid, 0);
    check(!rd_req_stb && !ack_stb, "R1", "strobes", {rd_req_stb, ack_stb}, 0);
    check(tx_serial == 16'h0 && tx_chan == 2'h0 && tx_size == 16'h0, "R1", "tx fields", tx_serial, 0);

    // R3/R6 same cycle: last payload byte and ack together
    run_frame(16'hA1B2, 8'h02, 8'b10_000_011, 16'd5, 19, -1, 1'b0);
    check(byte_cyc == stb_cyc, "R6", "last byte with ack same cycle", byte_cyc, stb_cyc);
    run_frame(16'h0F0E, 8'h02, 8'b01_111_001, 16'd9, 23, -1, 1'b1);
    check(byte_cyc == stb_cyc, "R6", "last byte with ack, gaps", byte_cyc, stb_cyc);
    // R4 padding ignored, R5 EOFE
    run_frame(16'h1234, 8'h02, 8'b01_000_100, 16'd4, 30, -1, 1'b0);
    // R4 clip at MAX_PAYLOAD
    run_frame(16'h2222, 8'h02, 8'b11_000_011, 16'd100, 14 + 70, -1, 1'b0);
    // R4 size zero
    run_frame(16'h3333, 8'h02, 8'b00_000_011, 16'd0, 20, -1, 1'b0);
    // R7 read with padding
    run_frame(16'hBEEF, 8'h03, 8'b11_000_000, 16'd7, 40, -1, 1'b0);
    held = tx_serial;
    // R8 null and poll, R10 fields hold
    run_frame(16'h5555, 8'h00, 8'b10_000_011, 16'd4, 20, -1, 1'b0);
    run_frame(16'h6666, 8'h01, 8'b01_000_011, 16'd4, 20, -1, 1'b0);
    check(tx_serial == held, "R10", "tx_serial held across dropped frames", tx_serial, held);
    // R9 error on last beat, error mid payload, short frame
    run_frame(16'h7777, 8'h02, 8'b10_000_011, 16'd6, 20, 19, 1'b0);
    run_frame(16'h8888, 8'h02, 8'b10_000_011, 16'd6, 20, 16, 1'b0);
    run_frame(16'h9999, 8'h03, 8'b10_000_000, 16'd0, 10, -1, 1'b0);
    check(tx_serial == held, "R9", "no field update after bad frames", tx_serial, held);

    // constrained random mix
    for (int n = 0; n < 160; n++) begin
      logic [7:0] ft;
      int len, err_at, r;
      r = $urandom % 10;
      ft = (r < 4) ? 8'h02 : (r < 7) ? 8'h03 : (r < 8) ? 8'h00 : (r < 9) ? 8'h01 : 8'h07;
      len = ($urandom % 12 == 0) ? 6 + $urandom % 8 : 14 + $urandom % 90;
      err_at = ($urandom % 10 == 0) ? int'($urandom % len) : -1;
      run_frame(16'($urandom), ft, 8'($urandom), 16'($urandom % 80), len, err_at, $urandom % 2 == 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule